// File: doc/BRIEF.md
# Link Mode Negotiation Resolver

This block picks the operating mode of a 10/100 Ethernet physical layer. It compares the locally offered abilities with the abilities advertised by the link partner and chooses the best mode both sides support. An outside pulse receiver delivers the partner's ability word together with a one-cycle valid strobe. The block also runs the restart sequence that turns negotiation on. Transmission is held silent for a long, parameterised period. The link then sits in link-fail until a usable partner word arrives.

Negotiation is on when either the management enable bit or the external enable pin is active. When both are inactive, the block stops negotiating. The speed and duplex are then copied straight from the management speed and duplex bits. The block drives the status bits seen by management: acknowledge, detected speed and detected duplex. It also drives a no-common-mode flag and the select line that picks the 10 Mbit/s or 100 Mbit/s link integrity monitor.

Top module: `an_mode_ctrl`

## Requirements
- R1: Negotiation is enabled when `cfg_an_en` is 1 or the synchronised `an_en_pin` is 1. The pin passes through PIN_SYNC_STAGES flip-flops, so it takes effect that many cycles later than the register bit.
- R2: When the block is disabled and sees the enable, `tx_quiet` goes to 1 on the next clock. It stays at 1 for exactly QUIET_CYCLES cycles. The default count falls inside the 1200 to 1500 ms window at 125 MHz.
- R3: When the quiet period ends, `tx_quiet` goes to 0 and `link_fail` goes to 1, with `stat_ack` at 0. The block then waits for a partner ability word.
- R4: Both ability words use the same bit layout: bit 3 is 100 Mbit/s full duplex, bit 2 is 100 half, bit 1 is 10 full and bit 0 is 10 half. The block takes the highest set bit of their AND, in that order. One cycle after `partner_vld` is sampled in link-fail, `stat_speed_100` and `stat_full_dplx` show the chosen mode.
- R5: A successful resolution sets `stat_ack` to 1 and `link_fail` to 0 on that same edge. Any restart or disable clears `stat_ack`.
- R6: If the AND of the two ability words is zero, the block stays in link-fail and `stat_ack` stays 0. `no_common` goes to 1 on the next cycle. It is cleared by a later successful resolution or by a disable.
- R7: `mon_sel_100` is 1 exactly when the speed in use is 100 Mbit/s. That speed is the resolved speed after negotiation, or `cfg_speed_100` when negotiation is off.
- R8: While disabled, `stat_speed_100` equals `cfg_speed_100` and `stat_full_dplx` equals `cfg_full_dplx`. In that state `tx_quiet`, `link_fail`, `stat_ack` and `no_common` are all 0.
- R9: The block ignores `partner_vld` during the quiet period and after a resolution. The resolved mode holds until the next restart.
- R10: Removing the enable in any phase puts the block in the disabled state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_an_en | input | 1 | Management negotiation enable bit |
| an_en_pin | input | 1 | External negotiation enable pin, asynchronous |
| cfg_speed_100 | input | 1 | Management forced speed, 1 = 100 Mbit/s |
| cfg_full_dplx | input | 1 | Management forced duplex, 1 = full |
| local_abil | input | 4 | Local ability word |
| partner_abil | input | 4 | Partner ability word |
| partner_vld | input | 1 | Partner word valid strobe |
| tx_quiet | output | 1 | Transmit blackout, link pulses included |
| link_fail | output | 1 | Link-fail state, waiting for partner |
| mon_sel_100 | output | 1 | Selects the 100 Mbit/s link integrity monitor |
| stat_ack | output | 1 | Negotiation complete status bit |
| stat_speed_100 | output | 1 | Speed detect status bit |
| stat_full_dplx | output | 1 | Duplex detect status bit |
| no_common | output | 1 | No shared mode found |

## Verification
Two events can land on the same clock edge. The partner strobe can arrive on the last edge of the quiet period. The enable can also drop on the same edge that a partner word arrives in link-fail. The bench holds `partner_vld` high through the whole blackout and expects no resolution on the expiring edge: `link_fail` must show first, and the acknowledge must follow one cycle later. It also pulses the strobe while clearing the enable and expects the disabled state with the acknowledge still 0. A table of ability pairs covers each priority level and the cases with no shared mode.

// File: rtl/an_mode_pkg.sv
package an_mode_pkg;

   localparam int N_MODES = 4;
   localparam int MODE_W  = $clog2(N_MODES);

   typedef logic [N_MODES-1:0] abil_t;

   // mode index equals ability bit position; higher index wins
   typedef enum logic [MODE_W-1:0] {
      MD_10_HALF  = 2'd0,
      MD_10_FULL  = 2'd1,
      MD_100_HALF = 2'd2,
      MD_100_FULL = 2'd3
   } mode_t;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_QUIET = 2'd1,
      ST_LFAIL = 2'd2,
      ST_UP    = 2'd3
   } seq_st_t;

   function automatic logic mode_fast(input mode_t m);
      return m[1];
   endfunction

   function automatic logic mode_full(input mode_t m);
      return m[0];
   endfunction

endpackage

// File: rtl/an_pin_sync.sv
module an_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_out
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("an_pin_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign pin_out = pin_in;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2+1-1:0], pin_in} >> 0;
         end
         assign pin_out = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/an_quiet_timer.sv
module an_quiet_timer #(
   parameter int QUIET_CYCLES = 168_750_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic done
);

   localparam int          CW   = $clog2(QUIET_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(QUIET_CYCLES - 1);

   generate
      if (QUIET_CYCLES < 1) begin : g_bad
         $error("an_quiet_timer: QUIET_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (start)              cnt <= LOAD;
      else if (run && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = run && (cnt == '0);

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD);

   assert_count_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/an_prio_resolve.sv
module an_prio_resolve
   import an_mode_pkg::*;
(
   input  abil_t local_abil,
   input  abil_t partner_abil,
   output logic  any_common,
   output mode_t best
);

   abil_t common;
   assign common = local_abil & partner_abil;

   // one candidate per mode; a higher mode overrides a lower one
   logic  [N_MODES-1:0] hit;
   mode_t               pick [N_MODES+1];

   assign pick[0] = MD_10_HALF;

   genvar gi;
   generate
      for (gi = 0; gi < N_MODES; gi++) begin : g_lvl
         assign hit[gi]    = common[gi];
         assign pick[gi+1] = hit[gi] ? mode_t'(gi) : pick[gi];
      end
   endgenerate

   assign best       = pick[N_MODES];
   assign any_common = |hit;

endmodule

// File: rtl/an_seq_fsm.sv
module an_seq_fsm
   import an_mode_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  logic    quiet_done,
   input  logic    partner_vld,
   input  logic    match_any,
   input  mode_t   match_mode,
   output seq_st_t st,
   output logic    timer_start,
   output mode_t   res_mode,
   output logic    nocom
);

   seq_st_t st_nx;
   mode_t   res_nx;
   logic    nocom_nx;

   always_comb begin
      st_nx    = st;
      res_nx   = res_mode;
      nocom_nx = nocom;
      unique case (st)
         ST_OFF: begin
            if (en) begin
               st_nx    = ST_QUIET;
               res_nx   = MD_10_HALF;
               nocom_nx = 1'b0;
            end
         end
         ST_QUIET: begin
            if (!en)             st_nx = ST_OFF;
            else if (quiet_done) st_nx = ST_LFAIL;
         end
         ST_LFAIL: begin
            if (!en) begin
               st_nx = ST_OFF;
            end else if (partner_vld) begin
               if (match_any) begin
                  st_nx    = ST_UP;
                  res_nx   = match_mode;
                  nocom_nx = 1'b0;
               end else begin
                  nocom_nx = 1'b1;
               end
            end
         end
         ST_UP: begin
            if (!en) st_nx = ST_OFF;
         end
         default: st_nx = ST_OFF;
      endcase
      if (!en) nocom_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         res_mode <= MD_10_HALF;
         nocom    <= 1'b0;
      end else begin
         st       <= st_nx;
         res_mode <= res_nx;
         nocom    <= nocom_nx;
      end
   end

   assign timer_start = (st == ST_OFF) && en;

   assert_quiet_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LFAIL && $past(st) == ST_QUIET) |-> $past(quiet_done));

   assert_up_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UP && $past(st) != ST_UP) |-> $past(partner_vld && match_any));

   assert_off_when_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st == ST_OFF));

endmodule

// File: rtl/an_mode_ctrl.sv
module an_mode_ctrl
   import an_mode_pkg::*;
#(
   parameter int QUIET_CYCLES    = 168_750_000, // 1.35 s at 125 MHz
   parameter int PIN_SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_an_en,
   input  logic       an_en_pin,
   input  logic       cfg_speed_100,
   input  logic       cfg_full_dplx,
   input  logic [3:0] local_abil,
   input  logic [3:0] partner_abil,
   input  logic       partner_vld,
   output logic       tx_quiet,
   output logic       link_fail,
   output logic       mon_sel_100,
   output logic       stat_ack,
   output logic       stat_speed_100,
   output logic       stat_full_dplx,
   output logic       no_common
);

   logic    pin_s, en_eff, qdone, tstart, m_any, nocom;
   mode_t   m_best, res_mode;
   seq_st_t st;

   an_pin_sync #(.STAGES(PIN_SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(an_en_pin), .pin_out(pin_s));

   assign en_eff = cfg_an_en | pin_s;

   an_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tstart),
      .run(st == ST_QUIET), .done(qdone));

   an_prio_resolve u_res (
      .local_abil(local_abil), .partner_abil(partner_abil),
      .any_common(m_any), .best(m_best));

   an_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en_eff), .quiet_done(qdone),
      .partner_vld(partner_vld), .match_any(m_any), .match_mode(m_best),
      .st(st), .timer_start(tstart), .res_mode(res_mode), .nocom(nocom));

   logic spd, dpx;
   always_comb begin
      if (st == ST_OFF) begin
         spd = cfg_speed_100;
         dpx = cfg_full_dplx;
      end else begin
         spd = mode_fast(res_mode);
         dpx = mode_full(res_mode);
      end
   end

   assign tx_quiet       = (st == ST_QUIET);
   assign link_fail      = (st == ST_LFAIL);
   assign stat_ack       = (st == ST_UP);
   assign stat_speed_100 = spd;
   assign stat_full_dplx = dpx;
   assign mon_sel_100    = spd;
   assign no_common      = nocom;

   assert_ack_vs_nocommon_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_ack && no_common));

   assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_ack && $past(stat_ack)) |-> ($stable(stat_speed_100) && $stable(stat_full_dplx)));

   assert_restart_clears_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_quiet |-> !stat_ack);

   assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_eff && $past(!en_eff)) |-> (!tx_quiet && !link_fail && !stat_ack && !no_common));

endmodule

// File: tb/test_an_mode_ctrl.sv
`timescale 1ns/1ps
module test_an_mode_ctrl;

   localparam int Q  = 20;
   localparam int SY = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_an_en = 0, an_en_pin = 0, cfg_speed_100 = 0, cfg_full_dplx = 0;
   logic [3:0] local_abil = 0, partner_abil = 0;
   logic partner_vld = 0;
   logic tx_quiet, link_fail, mon_sel_100, stat_ack, stat_speed_100, stat_full_dplx, no_common;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   an_mode_ctrl #(.QUIET_CYCLES(Q), .PIN_SYNC_STAGES(SY)) i_an_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_an_en(cfg_an_en), .an_en_pin(an_en_pin),
      .cfg_speed_100(cfg_speed_100), .cfg_full_dplx(cfg_full_dplx),
      .local_abil(local_abil), .partner_abil(partner_abil), .partner_vld(partner_vld),
      .tx_quiet(tx_quiet), .link_fail(link_fail), .mon_sel_100(mon_sel_100),
      .stat_ack(stat_ack), .stat_speed_100(stat_speed_100),
      .stat_full_dplx(stat_full_dplx), .no_common(no_common));

   // {local, partner, ack, speed100, full}
   localparam int NV = 9;
   localparam logic [10:0] VEC [NV] = '{
      {4'hF, 4'hF, 3'b111},
      {4'hF, 4'h7, 3'b110},
      {4'h3, 4'hF, 3'b101},
      {4'h1, 4'h1, 3'b100},
      {4'h5, 4'hA, 3'b000},
      {4'h6, 4'h3, 3'b101},
      {4'hC, 4'h4, 3'b110},
      {4'hA, 4'hB, 3'b111},
      {4'h0, 4'hF, 3'b000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic nt();
      @(negedge clk);
   endtask

   // clear and re-set the register enable, measure the blackout
   task automatic restart_reg();
      int n;
      cfg_an_en = 0; an_en_pin = 0;
      nt();
      chk("R8 off before restart", {tx_quiet, link_fail, stat_ack}, 3'b000);
      cfg_an_en = 1;
      n = 0;
      nt();
      while (tx_quiet && n < 4*Q) begin
         n++;
         nt();
      end
      chk("R2 blackout length", n, Q);
      chk("R3 link_fail after blackout", {link_fail, stat_ack}, 2'b10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) nt();
      chk("R8 reset state", {tx_quiet, link_fail, stat_ack, no_common, stat_speed_100}, 5'b0);
      rst_n = 1;
      nt();

      // R8 / R7 forced modes while disabled
      for (int k = 0; k < 4; k++) begin
         cfg_speed_100 = k[1]; cfg_full_dplx = k[0];
         nt();
         chk("R8 forced speed/duplex", {stat_speed_100, stat_full_dplx}, k[1:0]);
         chk("R7 monitor select forced", mon_sel_100, k[1]);
      end

      // table of resolutions
      for (int v = 0; v < NV; v++) begin
         restart_reg();
         local_abil = VEC[v][10:7]; partner_abil = VEC[v][6:3];
         partner_vld = 1;
         nt();
         partner_vld = 0;
         if (VEC[v][2]) begin
            chk("R4 resolved mode", {stat_speed_100, stat_full_dplx}, VEC[v][1:0]);
            chk("R5 ack set, link up", {stat_ack, link_fail, no_common}, 3'b100);
            chk("R7 monitor follows resolved speed", mon_sel_100, VEC[v][1]);
         end else begin
            chk("R6 no common mode", {stat_ack, link_fail, no_common}, 3'b011);
         end
      end

      // R6 flag clears on later success
      local_abil = 4'h4; partner_abil = 4'h4; partner_vld = 1;
      nt();
      partner_vld = 0;
      chk("R6 no_common cleared by success", {no_common, stat_ack, stat_speed_100, stat_full_dplx}, 4'b0110);

      // R9 strobe ignored after resolution
      partner_abil = 4'h1; local_abil = 4'h1; partner_vld = 1;
      nt();
      partner_vld = 0;
      nt();
      chk("R9 ignored after up", {stat_ack, stat_speed_100, stat_full_dplx}, 3'b110);

      // R5 restart clears ack
      cfg_an_en = 0;
      nt();
      cfg_an_en = 1;
      nt();
      chk("R5 ack cleared in blackout", {stat_ack, tx_quiet}, 2'b01);

      // R9 strobe held through blackout; expiring edge must not resolve
      local_abil = 4'hF; partner_abil = 4'h8; partner_vld = 1;
      while (tx_quiet) nt();
      chk("R9 expiry edge ignores strobe", {link_fail, stat_ack}, 2'b10);
      nt();
      partner_vld = 0;
      chk("R4 resolve right after blackout", {stat_ack, stat_speed_100, stat_full_dplx}, 3'b111);

      // R10 disable wins over a same-edge strobe
      restart_reg();
      partner_vld = 1; cfg_an_en = 0; cfg_speed_100 = 0; cfg_full_dplx = 1;
      nt();
      partner_vld = 0;
      chk("R10 disable beats strobe", {stat_ack, link_fail, tx_quiet, stat_speed_100, stat_full_dplx}, 5'b00001);

      // R10 disable during blackout
      cfg_an_en = 1;
      repeat (3) nt();
      cfg_an_en = 0;
      nt();
      chk("R10 disable in blackout", tx_quiet, 1'b0);

      // R1 pin enable with synchroniser latency
      an_en_pin = 1;
      for (int s = 0; s < SY; s++) begin
         nt();
         chk("R1 pin not yet seen", tx_quiet, 1'b0);
      end
      nt();
      chk("R1 pin enables negotiation", tx_quiet, 1'b1);
      an_en_pin = 0;
      repeat (SY) nt();
      chk("R1 still on before pin drop seen", tx_quiet, 1'b1);
      nt();
      chk("R1 both inputs low disables", tx_quiet, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule